// File: doc/BRIEF.md
# Prime-Modulus Bank Interleave Mapper

This block turns a flat word address into a (bank, offset) pair for a memory interleaved across a prime number of banks. The bank count is a prime of the form 2^M - 1, with M a parameter. With a prime bank count, strides that are powers of two no longer pile onto one bank; they rotate through every bank. The bank index is the address modulo that prime. The offset inside the bank is the address modulo a power-of-two bank depth. Because the two moduli share no factor, every address in range lands on its own pair.

No divider is used. Every address bit has a fixed residue, and the residues of the set bits are added. The sum is then reduced by end-around-carry folding. A folded result equal to the all-ones value is the same as zero and is mapped to zero. The result is registered once, so a request presented with its strobe comes out on the next clock.

Top module: `prime_bank_mapper`

## Requirements
- R1: For every input address x in 0 to 2^AW - 1, where AW = clog2(NB * 2^OW) and NB = 2^M - 1, the registered bank output equals x mod NB. With the defaults M=3 and OW=4, NB=7 and AW=7.
- R2: The registered offset output equals x mod 2^OW, which is the low OW address bits.
- R3: The output valid flag is high exactly in the cycle after a cycle with the input strobe high. It is low in the cycle after a cycle with the strobe low.
- R4: While reset (active low) is asserted, the output valid flag is low. It stays low after reset until a strobed request arrives.
- R5: The bank output is never NB or above. Addresses whose folded residue is all ones, such as 7, 14 and 126, give bank 0.
- R6: Over the addresses 0 to NB * 2^OW - 1, no two addresses give the same (bank, offset) pair.
- R7: For each power-of-two stride 2^j with (NB-1) * 2^j < 2^AW, the addresses k * 2^j for k = 0 to NB-1 reach all NB banks.
- R8: A cycle with the strobe low leaves the bank and offset outputs unchanged, whatever address is on the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Request strobe |
| in_addr | input | AW | Flat word address |
| out_vld | output | 1 | Result valid, one cycle after the strobe |
| out_bank | output | M | Bank index, address mod (2^M - 1) |
| out_off | output | OW | Word offset inside the bank |

## Verification
The bench sweeps every address in the input range. This catches a fold that stops early or misses an end-around carry, because such a design returns 7 instead of 0, or a value off by one, for addresses such as 7, 63 and 126. A missing final all-ones correction shows up as a bank equal to NB. A wrong residue constant for a high bit breaks the uniqueness scan and the stride scan, where some bank appears twice and another never appears. Idle cycles carrying a changed address expose a register that loads without the strobe, because its outputs drift.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

   // Residue of 2^k modulo 2^m - 1, which is 2^(k mod m).
   function automatic int unsigned bit_residue(input int unsigned k, input int unsigned m);
      return 32'd1 << (k % m);
   endfunction

   // Trial division, used only at elaboration.
   function automatic bit is_prime(input int unsigned n);
      if (n < 2) return 1'b0;
      for (int unsigned d = 2; d * d <= n; d++) begin
         if (n % d == 0) return 1'b0;
      end
      return 1'b1;
   endfunction

endpackage

// File: rtl/pbm_residue_sum.sv
module pbm_residue_sum
   import pbm_pkg::*;
#(
   parameter int M  = 3,
   parameter int AW = 7,
   parameter int SW = 6
)(
   input  logic [AW-1:0] addr,
   output logic [SW-1:0] sum
);

   logic [SW-1:0] term [AW];

   // One constant residue per address bit, gated by that bit.
   for (genvar k = 0; k < AW; k++) begin : g_term
      localparam int unsigned RES = bit_residue(k, M);
      assign term[k] = addr[k] ? SW'(RES) : '0;
   end

   always_comb begin
      sum = '0;
      for (int k = 0; k < AW; k++) begin
         sum = sum + term[k];
      end
   end

endmodule

// File: rtl/pbm_fold.sv
module pbm_fold #(
   parameter int M  = 3,
   parameter int SW = 6
)(
   input  logic [SW-1:0] sum,
   output logic [M-1:0]  bank
);

   localparam int FS = SW;
   localparam logic [M-1:0] ALL1 = '1;

   logic [SW-1:0] stage [FS+1];
   logic [M-1:0]  fin;

   assign stage[0] = sum;

   // Each stage adds the high part back onto the low M bits.
   for (genvar i = 0; i < FS; i++) begin : g_fold
      assign stage[i+1] = SW'(stage[i][M-1:0]) + (stage[i] >> M);
   end

   assign fin  = stage[FS][M-1:0];
   assign bank = (fin == ALL1) ? '0 : fin;

endmodule

// File: rtl/prime_bank_mapper.sv
module prime_bank_mapper
   import pbm_pkg::*;
#(
   parameter  int M  = 3,
   parameter  int OW = 4,
   localparam int NB = (1 << M) - 1,
   localparam int AW = $clog2(NB << OW)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_vld,
   input  logic [AW-1:0] in_addr,
   output logic          out_vld,
   output logic [M-1:0]  out_bank,
   output logic [OW-1:0] out_off
);

   localparam int SW = $clog2(AW * NB + 1);

   if (M < 2 || M > 16) begin : g_bad_m
      $error("prime_bank_mapper: M out of range");
   end
   if (!is_prime(NB)) begin : g_not_prime
      $error("prime_bank_mapper: 2^M-1 is not prime");
   end
   if (OW < 1 || OW > 24) begin : g_bad_ow
      $error("prime_bank_mapper: OW out of range");
   end

   logic [SW-1:0] rsum;
   logic [M-1:0]  bank_c;

   pbm_residue_sum #(.M(M), .AW(AW), .SW(SW)) u_sum (
      .addr (in_addr),
      .sum  (rsum)
   );

   pbm_fold #(.M(M), .SW(SW)) u_fold (
      .sum  (rsum),
      .bank (bank_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_vld <= 1'b0;
      else        out_vld <= in_vld;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_bank <= '0;
         out_off  <= '0;
      end else if (in_vld) begin
         out_bank <= bank_c;
         out_off  <= in_addr[OW-1:0];
      end
   end

   AST_BANK_MOD: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> (int'(out_bank) == int'($past(in_addr)) % NB)); // R1
   AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> (int'(out_off) == int'($past(in_addr)) % (1 << OW))); // R2
   AST_VLD_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld); // R3
   AST_VLD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> !out_vld); // R3
   AST_RST_CLEAR: assert property (@(posedge clk)
      !rst_n |=> !out_vld); // R4
   AST_BANK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> (int'(out_bank) < NB)); // R5
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> ($stable(out_bank) && $stable(out_off))); // R8

endmodule

// File: tb/sim_prime_bank_mapper.sv
module sim_prime_bank_mapper;

   localparam int M      = 3;
   localparam int OW     = 4;
   localparam int NB     = (1 << M) - 1;
   localparam int WB     = 1 << OW;
   localparam int AW     = $clog2(NB * WB);
   localparam int PERIOD = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_vld = 1'b0;
   logic [AW-1:0] in_addr = '0;
   logic          out_vld;
   logic [M-1:0]  out_bank;
   logic [OW-1:0] out_off;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   prime_bank_mapper #(.M(M), .OW(OW)) u0 (
      .clk, .rst_n, .in_vld, .in_addr, .out_vld, .out_bank, .out_off
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Present one request and sample the registered result a cycle later.
   task automatic issue(input int a, input bit v);
      @(negedge clk);
      in_addr = AW'(a);
      in_vld  = v;
      @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      in_vld = 1'b1;
      repeat (3) @(negedge clk);
      chk("R4 valid low in reset", int'(out_vld), 0);
      in_vld = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      chk("R4 valid low after reset", int'(out_vld), 0);
   endtask

   task automatic t_sweep();
      for (int a = 0; a < (1 << AW); a++) begin
         issue(a, 1'b1);
         chk("R1 bank", int'(out_bank), a % NB);
         chk("R2 offset", int'(out_off), a % WB);
         chk("R3 valid", int'(out_vld), 1);
      end
   endtask

   task automatic t_corners();
      int list [6] = '{7, 14, 63, 126, 127, 0};
      foreach (list[i]) begin
         issue(list[i], 1'b1);
         chk("R5 all-ones maps to zero", int'(out_bank), list[i] % NB);
         chk("R5 bank below NB", int'(int'(out_bank) < NB), 1);
      end
   endtask

   task automatic t_unique();
      bit seen [NB][WB];
      int dup = 0;
      foreach (seen[b, o]) seen[b][o] = 1'b0;
      for (int a = 0; a < NB * WB; a++) begin
         issue(a, 1'b1);
         if (seen[out_bank][out_off]) dup++;
         seen[out_bank][out_off] = 1'b1;
      end
      chk("R6 duplicate pairs", dup, 0);
   endtask

   task automatic t_stride();
      for (int j = 0; (NB - 1) * (1 << j) < (1 << AW); j++) begin
         bit [NB-1:0] hit = '0;
         for (int k = 0; k < NB; k++) begin
            issue(k * (1 << j), 1'b1);
            if (int'(out_bank) < NB) hit[out_bank] = 1'b1;
         end
         chk($sformatf("R7 stride 2^%0d banks reached", j), $countones(hit), NB);
      end
   endtask

   task automatic t_idle();
      issue(45, 1'b1);
      chk("R1 bank before idle", int'(out_bank), 45 % NB);
      issue(100, 1'b0);
      chk("R3 valid drops", int'(out_vld), 0);
      chk("R8 bank held", int'(out_bank), 45 % NB);
      chk("R8 offset held", int'(out_off), 45 % WB);
      issue(91, 1'b0);
      chk("R8 bank still held", int'(out_bank), 45 % NB);
      chk("R8 offset still held", int'(out_off), 45 % WB);
      issue(100, 1'b1);
      chk("R3 valid returns", int'(out_vld), 1);
      chk("R1 bank after idle", int'(out_bank), 100 % NB);
   endtask

   initial begin
      t_reset();
      t_sweep();
      t_corners();
      t_unique();
      t_stride();
      t_idle();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #(PERIOD * 200000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule